// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block holds the time of day as six binary-coded decimal digits: two for seconds, two for minutes and two for hours. An active-low pulse arriving once per second advances the time by one second. Each digit rolls over at its own limit and carries into the next digit up. When the time passes 23:59:59 it returns to 00:00:00, and the block drives a one-cycle active-low day pulse for a downstream date counter. All six digits are presented in parallel so that display decoders can drive the front panel directly.

Every pulse input is treated as asynchronous. Each one passes through a two-flop synchronizer and then a falling-edge detector on the system clock, so one assertion produces exactly one event however long the input is held low. A master clear zeroes the time. Two set inputs each step a single field for setting the time by hand: one steps the minutes units digit and one steps the hour. These set steps never carry into a higher field. When a set step and a second tick land in the same cycle, the tick is applied first and the set step is applied one cycle later, so neither event is lost.

Top module: `tod_bcd_chain`

## Requirements
- R1: The seconds units and minutes units digits are each a 4-bit BCD value from 0 to 9. On a second tick, a units digit that reads 9 returns to 0 and advances the tens digit of the same field.
- R2: The seconds tens and minutes tens digits are each a 4-bit BCD value from 0 to 5. On a carry, a tens digit that reads 5 returns to 0 and advances the units digit of the next field, so seconds tens feeds minutes units and minutes tens feeds hours units.
- R3: The hours tens digit stays within 0 to 2. The hours units digit stays within 0 to 9, and within 0 to 3 while hours tens is 2.
- R4: A second tick at 23:59:59 gives 00:00:00, with both hour digits cleared together. On that same clock edge `day_pulse_n_o` goes low for exactly one system clock cycle. It is high at all other times.
- R5: `sec_tick_n` is active low. The time advances by one second for each high-to-low transition, and holding the input low does not advance it again.
- R6: While `clear_i` is high, all six digits read zero, and any ticks or set requests that arrive during the clear are discarded.
- R7: A high-to-low transition on `set_min_n` steps the minutes units digit by one, from 9 back to 0. Minutes tens, the hours and the seconds are unchanged.
- R8: A high-to-low transition on `set_hr_n` steps the hour by one, from 23 back to 00. Minutes and seconds are unchanged, and `day_pulse_n_o` does not go low.
- R9: When a second tick and a set event are detected in the same cycle, the tick is applied first. The set step follows on the next cycle, and the final time reflects both in that order.
- R10: After the asynchronous reset `rst_n` is released, all digits read zero and `day_pulse_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Master clear, active high, asynchronous to clk |
| sec_tick_n | input | 1 | Once-per-second pulse, active low |
| set_min_n | input | 1 | Manual minutes-units step, active low |
| set_hr_n | input | 1 | Manual hour step, active low |
| sec_ones_o | output | 4 | Seconds units, BCD |
| sec_tens_o | output | 4 | Seconds tens, BCD |
| min_ones_o | output | 4 | Minutes units, BCD |
| min_tens_o | output | 4 | Minutes tens, BCD |
| hr_ones_o | output | 4 | Hours units, BCD |
| hr_tens_o | output | 4 | Hours tens, BCD |
| day_pulse_n_o | output | 1 | One-cycle active-low pulse at midnight |

## Verification
The assertions check on every cycle that each digit stays within its legal BCD range and that seconds units only steps by one or wraps to zero. They also check that the day pulse lasts a single cycle, that it coincides with an all-zero time, and that a clear held long enough leaves all six digits at zero. Some behaviour can only be shown by the bench's scenarios, because it depends on the history of the inputs. These are the carry path from seconds up to the day wrap, the guarantee of one step for each input edge, manual steps that do not carry (including the 23-to-00 hour step without a day pulse), and the ordering when a tick and a set request collide. The bench checks these against a reference model of seconds, minutes and hours.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int unsigned DIGIT_W  = 4;
    localparam int unsigned N_LOW    = 4;   // seconds units/tens, minutes units/tens
    localparam int unsigned N_PULSE  = 3;

    localparam int unsigned P_TICK   = 0;
    localparam int unsigned P_MIN    = 1;
    localparam int unsigned P_HOUR   = 2;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t [N_LOW-1:0] low;
        bcd_t             hr_u;
        bcd_t             hr_t;
        logic             pend_min;
        logic             pend_hr;
        logic             day_n;
    } tod_state_t;

    // Even positions are units digits (0..9), odd positions are tens digits (0..5).
    function automatic int unsigned low_limit(input int unsigned idx);
        return (idx % 2 == 0) ? 9 : 5;
    endfunction

endpackage

// File: rtl/tod_edge_sync.sv
module tod_edge_sync #(
    parameter int unsigned STAGES      = 2,
    parameter bit          IDLE        = 1'b1,
    parameter bit          DETECT_FALL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic evt_o
);

    localparam int unsigned DEPTH = DETECT_FALL ? STAGES + 1 : STAGES;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= {DEPTH{IDLE}};
        end else begin
            sh_q <= sh_d;
        end
    end

    generate
        if (DETECT_FALL) begin : g_fall
            // previous synchronized sample high, current low
            assign evt_o = sh_q[DEPTH-1] & ~sh_q[DEPTH-2];
        end else begin : g_level
            assign evt_o = sh_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/tod_digit_step.sv
module tod_digit_step #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned LIMIT = 9
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic             en_i,
    output logic [WIDTH-1:0] nxt_o,
    output logic             at_top_o
);

    localparam logic [WIDTH-1:0] TOP = WIDTH'(LIMIT);

    always_comb begin
        at_top_o = (cur_i == TOP);
        if (!en_i) begin
            nxt_o = cur_i;
        end else if (cur_i >= TOP) begin
            nxt_o = '0;
        end else begin
            nxt_o = cur_i + 1'b1;
        end
    end

endmodule

// File: rtl/tod_hour_step.sv
module tod_hour_step #(
    parameter int unsigned WIDTH         = 4,
    parameter int unsigned HOURS_PER_DAY = 24
) (
    input  logic [WIDTH-1:0] units_i,
    input  logic [WIDTH-1:0] tens_i,
    input  logic             en_i,
    output logic [WIDTH-1:0] units_o,
    output logic [WIDTH-1:0] tens_o,
    output logic             at_last_o
);

    localparam logic [WIDTH-1:0] TENS_LAST  = WIDTH'((HOURS_PER_DAY - 1) / 10);
    localparam logic [WIDTH-1:0] UNITS_LAST = WIDTH'((HOURS_PER_DAY - 1) % 10);
    localparam logic [WIDTH-1:0] UNITS_MAX  = WIDTH'(9);

    always_comb begin
        // last hour of the day needs both digits
        at_last_o = (tens_i == TENS_LAST) && (units_i == UNITS_LAST);
        units_o   = units_i;
        tens_o    = tens_i;
        if (en_i) begin
            if (at_last_o) begin
                units_o = '0;
                tens_o  = '0;
            end else if (units_i >= UNITS_MAX) begin
                units_o = '0;
                tens_o  = tens_i + 1'b1;
            end else begin
                units_o = units_i + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tod_bcd_chain.sv
module tod_bcd_chain
    import tod_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned HOURS_PER_DAY = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       sec_tick_n,
    input  logic       set_min_n,
    input  logic       set_hr_n,
    output logic [3:0] sec_ones_o,
    output logic [3:0] sec_tens_o,
    output logic [3:0] min_ones_o,
    output logic [3:0] min_tens_o,
    output logic [3:0] hr_ones_o,
    output logic [3:0] hr_tens_o,
    output logic       day_pulse_n_o
);

    tod_state_t st_d, st_q;

    logic [N_PULSE-1:0] pulse_raw;
    logic [N_PULSE-1:0] pulse_fall;
    logic               clear_lvl;

    logic [N_LOW-1:0]   low_en;
    logic [N_LOW-1:0]   low_top;
    bcd_t [N_LOW-1:0]   low_nxt;

    logic               tick_go, min_req, hr_req, min_go, hr_go;
    logic               hr_tick, hr_en, hr_last;
    bcd_t               hr_u_nxt, hr_t_nxt;

    // ---------------- input synchronizers ----------------
    assign pulse_raw[P_TICK] = sec_tick_n;
    assign pulse_raw[P_MIN]  = set_min_n;
    assign pulse_raw[P_HOUR] = set_hr_n;

    generate
        for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
            tod_edge_sync #(
                .STAGES      (SYNC_STAGES),
                .IDLE        (1'b1),
                .DETECT_FALL (1'b1)
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (pulse_raw[g]),
                .evt_o (pulse_fall[g])
            );
        end
    endgenerate

    tod_edge_sync #(
        .STAGES      (SYNC_STAGES),
        .IDLE        (1'b0),
        .DETECT_FALL (1'b0)
    ) u_clear_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (clear_i),
        .evt_o (clear_lvl)
    );

    // ---------------- digit steppers ----------------
    generate
        for (genvar i = 0; i < N_LOW; i++) begin : g_low
            tod_digit_step #(
                .WIDTH (DIGIT_W),
                .LIMIT (low_limit(i))
            ) u_digit (
                .cur_i    (st_q.low[i]),
                .en_i     (low_en[i]),
                .nxt_o    (low_nxt[i]),
                .at_top_o (low_top[i])
            );
        end
    endgenerate

    tod_hour_step #(
        .WIDTH         (DIGIT_W),
        .HOURS_PER_DAY (HOURS_PER_DAY)
    ) u_hour (
        .units_i   (st_q.hr_u),
        .tens_i    (st_q.hr_t),
        .en_i      (hr_en),
        .units_o   (hr_u_nxt),
        .tens_o    (hr_t_nxt),
        .at_last_o (hr_last)
    );

    // ---------------- event arbitration and carry enables ----------------
    always_comb begin
        tick_go = pulse_fall[P_TICK];
        min_req = pulse_fall[P_MIN]  | st_q.pend_min;
        hr_req  = pulse_fall[P_HOUR] | st_q.pend_hr;
        // the tick owns the cycle; a set request waits one cycle behind it
        min_go  = min_req & ~tick_go;
        hr_go   = hr_req  & ~tick_go;

        low_en[0] = tick_go;
        low_en[1] = tick_go & low_top[0];
        low_en[2] = (tick_go & low_top[0] & low_top[1]) | min_go;
        low_en[3] = tick_go & low_top[0] & low_top[1] & low_top[2];
        hr_tick   = tick_go & (&low_top);
        hr_en     = hr_tick | hr_go;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d          = st_q;
        st_d.low      = low_nxt;
        st_d.hr_u     = hr_u_nxt;
        st_d.hr_t     = hr_t_nxt;
        st_d.pend_min = min_req & tick_go;
        st_d.pend_hr  = hr_req  & tick_go;
        st_d.day_n    = ~(hr_tick & hr_last);
        if (clear_lvl) begin
            st_d       = '0;
            st_d.day_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.day_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_ones_o    = st_q.low[0];
    assign sec_tens_o    = st_q.low[1];
    assign min_ones_o    = st_q.low[2];
    assign min_tens_o    = st_q.low[3];
    assign hr_ones_o     = st_q.hr_u;
    assign hr_tens_o     = st_q.hr_t;
    assign day_pulse_n_o = st_q.day_n;

endmodule

// File: rtl/tod_bcd_chain_chk.sv
module tod_bcd_chain_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clear_i,
    input logic [3:0] sec_ones_o,
    input logic [3:0] sec_tens_o,
    input logic [3:0] min_ones_o,
    input logic [3:0] min_tens_o,
    input logic [3:0] hr_ones_o,
    input logic [3:0] hr_tens_o,
    input logic       day_pulse_n_o
);

    logic all_zero;
    assign all_zero = (sec_ones_o == 4'd0) && (sec_tens_o == 4'd0) &&
                      (min_ones_o == 4'd0) && (min_tens_o == 4'd0) &&
                      (hr_ones_o  == 4'd0) && (hr_tens_o  == 4'd0);

    a_r1_units_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_ones_o <= 4'd9) && (min_ones_o <= 4'd9));

    a_r1_sec_units_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_ones_o) |->
            (sec_ones_o == 4'($past(sec_ones_o) + 4'd1)) || (sec_ones_o == 4'd0));

    a_r2_tens_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tens_o <= 4'd5) && (min_tens_o <= 4'd5));

    a_r3_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_tens_o <= 4'd2) && (hr_ones_o <= 4'd9) &&
        ((hr_tens_o != 4'd2) || (hr_ones_o <= 4'd3)));

    a_r4_day_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !day_pulse_n_o |=> day_pulse_n_o);

    a_r4_day_at_midnight: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(day_pulse_n_o) |-> all_zero);

    // sized for the default two-stage clear synchronizer
    a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && $past(clear_i) && $past(clear_i, 2) && $past(clear_i, 3)) |-> all_zero);

endmodule

bind tod_bcd_chain tod_bcd_chain_chk u_chk (.*);

// File: tb/tod_bcd_chain_test.sv
module tod_bcd_chain_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       clear_i;
    logic       sec_tick_n;
    logic       set_min_n;
    logic       set_hr_n;
    logic [3:0] sec_ones_o, sec_tens_o, min_ones_o, min_tens_o, hr_ones_o, hr_tens_o;
    logic       day_pulse_n_o;

    always #10 clk = ~clk;   // 50 MHz

    tod_bcd_chain uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (clear_i),
        .sec_tick_n    (sec_tick_n),
        .set_min_n     (set_min_n),
        .set_hr_n      (set_hr_n),
        .sec_ones_o    (sec_ones_o),
        .sec_tens_o    (sec_tens_o),
        .min_ones_o    (min_ones_o),
        .min_tens_o    (min_tens_o),
        .hr_ones_o     (hr_ones_o),
        .hr_tens_o     (hr_tens_o),
        .day_pulse_n_o (day_pulse_n_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int day_seen = 0;
    int exp_days = 0;
    int eh = 0, em = 0, es = 0;

    always @(negedge clk) begin
        if (rst_n === 1'b1 && day_pulse_n_o === 1'b0) day_seen++;
    end

    // ---------------- reference model ----------------
    function automatic logic [23:0] pack_time(input int h, input int m, input int s);
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
    endfunction

    task automatic model_tick();
        es++;
        if (es == 60) begin
            es = 0; em++;
            if (em == 60) begin
                em = 0; eh++;
                if (eh == 24) begin
                    eh = 0; exp_days++;
                end
            end
        end
    endtask

    task automatic model_min();
        em = (em / 10) * 10 + ((em % 10) + 1) % 10;
    endtask

    task automatic model_hr();
        eh = (eh + 1) % 24;
    endtask

    // ---------------- checks ----------------
    task automatic check_time(input string tag);
        logic [23:0] act, exp;
        act = {hr_tens_o, hr_ones_o, min_tens_o, min_ones_o, sec_tens_o, sec_ones_o};
        exp = pack_time(eh, em, es);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: time act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_days(input string tag);
        n_cmp++;
        if (day_seen != exp_days) begin
            n_bad++;
            $display("FAIL %s: day pulses act=%0d exp=%0d", tag, day_seen, exp_days);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%b exp=%b", tag, act, exp);
        end
    endtask

    // ---------------- stimulus ----------------
    // sel bit0 tick, bit1 minutes set, bit2 hour set; low for hold cycles
    task automatic pulse(input logic [2:0] sel, input int hold);
        @(negedge clk);
        if (sel[0]) sec_tick_n = 1'b0;
        if (sel[1]) set_min_n  = 1'b0;
        if (sel[2]) set_hr_n   = 1'b0;
        repeat (hold) @(negedge clk);
        sec_tick_n = 1'b1;
        set_min_n  = 1'b1;
        set_hr_n   = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_tick();
        pulse(3'b001, 1);
        model_tick();
    endtask

    task automatic do_min();
        pulse(3'b010, 1);
        model_min();
    endtask

    task automatic do_hr();
        pulse(3'b100, 1);
        model_hr();
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_i = 1'b1;
        sec_tick_n = 1'b0;       // requests during clear must be discarded
        repeat (2) @(negedge clk);
        sec_tick_n = 1'b1;
        repeat (3) @(negedge clk);
        clear_i = 1'b0;
        repeat (3) @(negedge clk);
        eh = 0; em = 0; es = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        int unsigned r;
        rst_n = 1'b0;
        clear_i = 1'b0;
        sec_tick_n = 1'b1;
        set_min_n = 1'b1;
        set_hr_n = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check_time("R10 reset digits");
        check_bit("R10 reset day pulse", day_pulse_n_o, 1'b1);

        // R1 seconds units stepping and carry into tens
        for (int i = 0; i < 12; i++) begin
            do_tick();
            check_time("R1 tick");
        end

        // R5 one step per edge even when held low
        pulse(3'b001, 10);
        model_tick();
        check_time("R5 long low");

        // R7 minutes units wraps without carry
        for (int i = 0; i < 12; i++) begin
            do_min();
            check_time("R7 set minutes");
        end

        // R8 hour steps, 23 -> 00 with no day pulse; R3 range
        for (int i = 0; i < 26; i++) begin
            do_hr();
            check_time("R3 R8 set hour");
        end
        check_days("R8 no day pulse on set wrap");

        // R6 clear
        do_clear();
        check_time("R6 clear");
        check_days("R6 clear");

        // R9 collision: 00:09:59 then tick and minutes set together
        for (int i = 0; i < 9; i++) do_min();
        for (int i = 0; i < 59; i++) do_tick();
        check_time("R9 setup");
        pulse(3'b011, 1);
        model_tick();
        model_min();
        check_time("R9 tick then set");
        // hour set colliding with a tick
        pulse(3'b101, 1);
        model_tick();
        model_hr();
        check_time("R9 tick then hour set");

        // R2 / R4 carry chain up to midnight
        do_clear();
        for (int i = 0; i < 23; i++) do_hr();
        check_time("R3 23h");
        for (int i = 0; i < 3599; i++) begin
            do_tick();
            check_time("R2 carry chain");
        end
        check_days("R4 before midnight");
        do_tick();
        check_time("R4 midnight wrap");
        check_days("R4 one day pulse");
        do_tick();
        check_time("R4 after midnight");

        // random mix
        r = $urandom(32'd1357);
        for (int i = 0; i < 600; i++) begin
            r = $urandom_range(0, 99);
            if (r < 60) begin
                do_tick();
            end else if (r < 75) begin
                do_min();
            end else if (r < 88) begin
                do_hr();
            end else if (r < 96) begin
                pulse(3'b111, 1);
                model_tick();
                model_min();
                model_hr();
            end else begin
                do_clear();
            end
            check_time("R1 R9 random");
        end
        check_days("R4 R8 random day count");

        summary();
        $finish;
    end

endmodule